// File: doc/BRIEF.md
# SPI Slave to Memory-Bus Bridge

This block lets an SPI master reach a passive parallel device, such as a RAM or a display controller, without any firmware on the slave side. SCK, SS and MOSI are oversampled by the system clock. The first word shifted in after SS goes low is taken as an address and driven onto the bus. The bridge then issues a one-cycle read strobe and loads the returned data into its transmit register, so the master gets that data on MISO during the next word.

Every later word is full duplex. While the prepared read data goes out on MISO, the master's write data comes in on MOSI. When a whole word has arrived, the bridge writes it to the current address with a one-cycle write strobe. It then steps the address by one and reads the next location. Any of the four SPI clock formats can be selected. The address word and the data words each have their own length parameter.

Top module: `spi_bus_bridge`

## Requirements
- R1: After synchronous reset, `bus_rd`, `bus_we` and `spi_miso` are 0, and `bus_addr` and `bus_wdata` are all zeros.
- R2: When `spi_ss_n` has been high for three system clocks, `spi_miso` is 0. During the address word of a transaction, every bit driven on `spi_miso` is 0.
- R3: The first ADDR_W bits received after `spi_ss_n` falls, most significant bit first, appear on `bus_addr` no later than six system clocks after the sample edge of the last address bit.
- R4: After the address word, one `bus_rd` pulse is issued at that address. The bridge captures `bus_rdata` on the cycle after the pulse, which is a read latency of one clock. The first data word it sends on MISO, MSB first, is that value.
- R5: Each fully received data word of DATA_W bits, MSB first, is placed on `bus_wdata` with a single `bus_we` pulse. `bus_addr` is held stable during the pulse and addresses the location that was read for that word.
- R6: On the cycle after each `bus_we` pulse, `bus_addr` is one higher, wrapping modulo 2^ADDR_W. A new read follows, and its data is the next word sent on MISO.
- R7: `bus_rd` and `bus_we` are each exactly one system clock wide, and they are never high together.
- R8: Raising `spi_ss_n` before a data word is complete discards the partial word with no `bus_we`. The next transaction starts again with an address word.
- R9: `cpol` selects the idle level of SCK. With `cpha`=0 the bridge samples on the leading edge and changes MISO on the trailing edge. With `cpha`=1 it changes MISO on the leading edge and samples on the trailing edge. Leading and trailing edges are never both detected in one cycle.
- R10: The address word length (ADDR_W) and the data word length (DATA_W) are independent. The internal bit count never reaches the longer of the two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| spi_sck | input | 1 | Serial clock from the master |
| spi_ss_n | input | 1 | Slave select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, 0 when deselected |
| bus_addr | output | ADDR_W | Bus address |
| bus_rdata | input | DATA_W | Read data, valid one clock after `bus_rd` |
| bus_wdata | output | DATA_W | Write data |
| bus_rd | output | 1 | One-clock read strobe |
| bus_we | output | 1 | One-clock write strobe |

## Verification
An SCK edge reaches the bridge logic three system clocks after it happens on the pin. The address register updates one clock after that. The write strobe follows one clock after a word completes, the read strobe one clock later, and the transmit load two clocks after the read strobe. The result is on MISO one clock after the load, roughly nine clocks after the last sample edge of the word. The bench holds each SCK half period for ten system clocks. It reads MISO at the moment it moves SCK, before the bridge can react, and it checks the address bus at the end of the half period that follows the last address bit. Write counts, memory contents and the final address are compared thirty clocks after SS rises, once the bus sequence has finished.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_INC,
    SQ_WAIT,
    SQ_LOAD
  } seq_state_t;

  function automatic int larger(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cpol,
  input  logic cpha,
  input  logic sck_in,
  input  logic ss_n_in,
  input  logic mosi_in,
  output logic ss_act,
  output logic mosi_bit,
  output logic sample_evt,
  output logic shift_evt
);

  logic [SYNC_STAGES:0]   sck_pipe;
  logic [SYNC_STAGES-1:0] ss_pipe;
  logic [SYNC_STAGES-1:0] mosi_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_pipe  <= '0;
      ss_pipe   <= '1;
      mosi_pipe <= '0;
    end else begin
      sck_pipe  <= {sck_pipe[SYNC_STAGES-1:0], sck_in};
      ss_pipe   <= {ss_pipe[SYNC_STAGES-2:0], ss_n_in};
      mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], mosi_in};
    end
  end

  logic rise, fall, lead, trail;

  always_comb begin
    rise       = sck_pipe[SYNC_STAGES-1] & ~sck_pipe[SYNC_STAGES];
    fall       = ~sck_pipe[SYNC_STAGES-1] & sck_pipe[SYNC_STAGES];
    lead       = cpol ? fall : rise;
    trail      = cpol ? rise : fall;
    sample_evt = cpha ? trail : lead;
    shift_evt  = cpha ? lead : trail;
    ss_act     = ~ss_pipe[SYNC_STAGES-1];
    mosi_bit   = mosi_pipe[SYNC_STAGES-1];
  end

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sample_evt && shift_evt)); // R9

endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter
  import spi_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WORD_W = larger(ADDR_W, DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ss_act,
  input  logic              mosi_bit,
  input  logic              sample_evt,
  input  logic              shift_evt,
  input  logic              load_tx,
  input  logic [DATA_W-1:0] tx_data,
  output logic              word_done,
  output logic              word_is_addr,
  output logic [WORD_W-1:0] word,
  output logic              miso
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic              first_q;
  logic [WORD_W-1:0] rx_q;
  logic [DATA_W-1:0] tx_q;
  logic [CNT_W-1:0]  last_idx;

  always_comb last_idx = first_q ? CNT_W'(ADDR_W - 1) : CNT_W'(DATA_W - 1);

  // receive side: bit counting and word framing
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt      <= '0;
      first_q      <= 1'b1;
      rx_q         <= '0;
      word_done    <= 1'b0;
      word_is_addr <= 1'b0;
      word         <= '0;
    end else if (!ss_act) begin
      bit_cnt   <= '0;
      first_q   <= 1'b1;
      rx_q      <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (sample_evt) begin
        if (bit_cnt == last_idx) begin
          word         <= {rx_q[WORD_W-2:0], mosi_bit};
          word_done    <= 1'b1;
          word_is_addr <= first_q;
          first_q      <= 1'b0;
          bit_cnt      <= '0;
          rx_q         <= '0;
        end else begin
          rx_q    <= {rx_q[WORD_W-2:0], mosi_bit};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // transmit side: shift only inside a word, never on the edge that opens one
  always_ff @(posedge clk) begin
    if (rst || !ss_act) begin
      tx_q <= '0;
    end else if (load_tx) begin
      tx_q <= tx_data;
    end else if (shift_evt && bit_cnt != '0) begin
      tx_q <= {tx_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) miso <= 1'b0;
    else     miso <= ss_act & tx_q[DATA_W-1];
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    bit_cnt < CNT_W'(WORD_W)); // R10

endmodule

// File: rtl/spi_bus_seq.sv
module spi_bus_seq
  import spi_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WORD_W = larger(ADDR_W, DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_done,
  input  logic              word_is_addr,
  input  logic [WORD_W-1:0] word,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              bus_we,
  output logic              load_tx
);

  seq_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_rd    <= 1'b0;
      bus_we    <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (word_done) begin
            if (word_is_addr) begin
              bus_addr <= word[ADDR_W-1:0];
              bus_rd   <= 1'b1;
              state    <= SQ_WAIT;
            end else begin
              bus_wdata <= word[DATA_W-1:0];
              bus_we    <= 1'b1;
              state     <= SQ_INC;
            end
          end
        end
        SQ_INC: begin
          bus_we   <= 1'b0;
          bus_addr <= bus_addr + 1'b1;
          bus_rd   <= 1'b1;
          state    <= SQ_WAIT;
        end
        SQ_WAIT: begin
          bus_rd <= 1'b0;
          state  <= SQ_LOAD;
        end
        SQ_LOAD: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb load_tx = (state == SQ_LOAD);

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> !bus_rd); // R7
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> !bus_we); // R7
  AST_RD_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_we)); // R7
  AST_ADDR_HELD_WE: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> $stable(bus_addr)); // R5
  AST_INC_AFTER_WE: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_we) |-> (bus_addr == ADDR_W'($past(bus_addr) + 1'b1))); // R6

endmodule

// File: rtl/spi_bus_bridge.sv
module spi_bus_bridge
  import spi_bridge_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              spi_sck,
  input  logic              spi_ss_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              bus_we
);

  localparam int WORD_W = larger(ADDR_W, DATA_W);

  logic              ss_act, mosi_bit, sample_evt, shift_evt;
  logic              word_done, word_is_addr, load_tx;
  logic [WORD_W-1:0] word;

  spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cpol(cpol), .cpha(cpha),
    .sck_in(spi_sck), .ss_n_in(spi_ss_n), .mosi_in(spi_mosi),
    .ss_act(ss_act), .mosi_bit(mosi_bit),
    .sample_evt(sample_evt), .shift_evt(shift_evt)
  );

  spi_word_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .ss_act(ss_act), .mosi_bit(mosi_bit),
    .sample_evt(sample_evt), .shift_evt(shift_evt),
    .load_tx(load_tx), .tx_data(bus_rdata),
    .word_done(word_done), .word_is_addr(word_is_addr), .word(word),
    .miso(spi_miso)
  );

  spi_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst(rst), .word_done(word_done), .word_is_addr(word_is_addr),
    .word(word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_we(bus_we), .load_tx(load_tx)
  );

  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(spi_ss_n, 1) && $past(spi_ss_n, 2) && $past(spi_ss_n, 3)) |-> !spi_miso); // R2

endmodule

// File: tb/spi_bus_bridge_tb.sv
module spi_bus_bridge_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int HP    = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpol = 1'b0, cpha = 1'b0;
  logic sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic miso, rd, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] rdata = '0;
  logic [DW-1:0] wdata;

  int n_cmp = 0;
  int n_bad = 0;
  int we_cnt = 0, overlap = 0, wide = 0;
  logic rd_prev = 1'b0, we_prev = 1'b0;
  logic [DW-1:0] mem    [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  logic [DW-1:0] tx_words [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_bus_bridge #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .cpol(cpol), .cpha(cpha),
    .spi_sck(sck), .spi_ss_n(ss_n), .spi_mosi(mosi), .spi_miso(miso),
    .bus_addr(addr), .bus_rdata(rdata), .bus_wdata(wdata),
    .bus_rd(rd), .bus_we(we)
  );

  function automatic logic [DW-1:0] init_val(input int i);
    return DW'(i * 37 + 5);
  endfunction

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  // passive device: one-clock read latency
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_val(i);
    end else begin
      if (rd) rdata <= mem[addr];
      if (we) mem[addr] <= wdata;
    end
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (we) we_cnt <= we_cnt + 1;
      if (rd && we) overlap <= overlap + 1;
      if ((rd && rd_prev) || (we && we_prev)) wide <= wide + 1;
    end
    rd_prev <= rd;
    we_prev <= we;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic do_bit(input logic b, output logic m);
    if (!cpha) begin
      mosi = b; tick(HP); m = miso; sck = ~cpol; tick(HP); sck = cpol;
    end else begin
      sck = ~cpol; mosi = b; tick(HP); m = miso; sck = cpol; tick(HP);
    end
  endtask

  task automatic xfer(input logic p, input logic h, input logic [AW-1:0] a,
                      input int nw, input int abort_bits);
    logic m;
    logic [AW-1:0] arx;
    logic [DW-1:0] got;
    logic [AW-1:0] cur;
    int we_before, bad;
    cpol = p; cpha = h; sck = p; tick(6);
    chk(miso == 1'b0, "R2 idle MISO", miso, 0);
    we_before = we_cnt;
    cur = a;
    arx = '0;
    ss_n = 1'b0; tick(HP);
    for (int i = AW-1; i >= 0; i--) begin
      do_bit(a[i], m);
      arx = {arx[AW-2:0], m};
    end
    chk(arx == '0, "R2 MISO during address word", arx, 0);
    chk(addr == a, "R3 R10 address on bus", addr, a);
    for (int w = 0; w < nw; w++) begin
      got = '0;
      for (int i = DW-1; i >= 0; i--) begin
        do_bit(tx_words[w][i], m);
        got = {got[DW-2:0], m};
      end
      chk(got == shadow[cur], (w == 0) ? "R4 R9 first read word" : "R6 R9 next read word",
          got, shadow[cur]);
      shadow[cur] = tx_words[w];
      cur = next_addr(cur);
    end
    for (int i = 0; i < abort_bits; i++) do_bit(1'($urandom), m);
    tick(HP);
    ss_n = 1'b1;
    tick(30);
    chk(we_cnt - we_before == nw, "R5 R8 write strobe count", we_cnt - we_before, nw);
    bad = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] !== shadow[i]) bad++;
    chk(bad == 0, "R5 R8 memory contents", bad, 0);
    chk(addr == cur, "R6 final address", addr, cur);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'd7321);
    for (int i = 0; i < DEPTH; i++) shadow[i] = init_val(i);
    tick(5);
    rst = 1'b0;
    tick(1);
    chk(!rd && !we && !miso && addr == '0 && wdata == '0, "R1 reset state",
        {rd, we, miso, addr, wdata}, 0);

    // directed: all four formats
    for (int md = 0; md < 4; md++) begin
      tx_words[0] = DW'(8'hA5 ^ md); tx_words[1] = DW'(8'h3C + md);
      xfer(md[1], md[0], AW'(5 + 3*md), 2, 0);
    end
    // address wrap
    tx_words[0] = 8'h11; tx_words[1] = 8'h22; tx_words[2] = 8'h33;
    xfer(1'b0, 1'b1, AW'(DEPTH-1), 3, 0);
    // abort during first and second data words
    tx_words[0] = 8'hFF;
    xfer(1'b1, 1'b0, AW'(10), 0, 4);
    tx_words[0] = 8'h5A;
    xfer(1'b0, 1'b0, AW'(20), 1, 3);

    // constrained random traffic
    for (int t = 0; t < 16; t++) begin
      int nw, ab;
      nw = int'($urandom_range(1, 4));
      ab = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, DW-1)) : 0;
      for (int w = 0; w < 4; w++) tx_words[w] = DW'($urandom);
      xfer(1'($urandom), 1'($urandom), AW'($urandom), nw, ab);
    end

    chk(overlap == 0, "R7 RD and WE together", overlap, 0);
    chk(wide == 0, "R7 strobe wider than one clock", wide, 0);
    summary();
    $finish;
  end

endmodule